// File: doc/BRIEF.md
# Trap Entry and Interrupt Return Sequencer

This block is the control sequencer a small multithreaded processor core uses when it takes a software trap or returns from an interrupt handler. The core keeps a 64-bit program counter per thread, a shared status word with one byte per thread, and a 16-bit stack pointer into a byte-wide memory. The decoder starts the block with a one-cycle strobe, an operation code, the thread number and the live PC, status word and stack pointer. The block then drives the byte memory port by itself, one access per cycle, and reports the new PC, status word and stack pointer with a one-cycle done strobe.

On a trap the block pushes the return address (the current PC minus one) as eight bytes, most significant first. It then pushes the executing thread's status byte and sets that thread's interrupt-disable flag. Last, it reads the handler address from two separate 4-byte vector regions. On a return it pulls the status byte back into the thread's lane and pulls eight PC bytes, least significant first, then adds one. A third operation fetches the start-up PC from the boot vector.

Top module: `trap_return_seq`

## Requirements
- R1: A trap (op code 0) writes nine bytes at stack addresses SP, SP-1, ..., SP-8. The first eight are bytes 7 down to 0 of PC-1, most significant byte first. The ninth is byte `tid` of the status word, bits 8*tid+7..8*tid, taken before the flag in R2 is set.
- R2: After a trap, bit 2 (interrupt disable) of the executing thread's status byte is 1 and every other status bit is unchanged.
- R3: After its pushes, a trap reads 0xFFE0..0xFFE3 as new-PC bytes 0..3 and 0xFFF0..0xFFF3 as bytes 4..7, in that order, and returns the assembled little-endian value as the new PC.
- R4: A return (op code 1) reads nine bytes at SP+1..SP+9. The first byte replaces the thread's status byte. The other eight form a little-endian value, least significant byte first, and the new PC is that value plus one, modulo 2^64.
- R5: A boot fetch (op code 2) reads 0xFFC0..0xFFC7 as PC bytes 0..7, little-endian. Status word and stack pointer come back unchanged.
- R6: The returned stack pointer is SP-9 after a trap and SP+9 after a return, modulo 2^16. Stack addresses wrap the same way.
- R7: The memory read data is taken in the same cycle as the address. A trap makes 17 accesses, a return 9 and a boot fetch 8, in consecutive cycles starting the cycle after the accepting edge. Done is high for exactly one cycle, the cycle after the last access.
- R8: A start strobe is ignored while a sequence is running, including during its last access. A start with op code 3 starts nothing. A start during the done cycle is accepted.
- R9: After reset, done, write enable and read enable are low until a sequence is started.
- R10: Write enable and read enable are never high in the same cycle. Each access moves one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle start strobe |
| op_i | input | 2 | 0 trap, 1 return, 2 boot fetch, 3 none |
| tid_i | input | 2 | Executing thread index |
| pc_i | input | 64 | Current PC of the thread |
| status_i | input | 32 | Shared status word, one byte per thread |
| sp_i | input | 16 | Current stack pointer |
| mem_addr_o | output | 16 | Byte memory address |
| mem_we_o | output | 1 | Byte write enable |
| mem_re_o | output | 1 | Byte read enable |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid in the same cycle as the address |
| done_o | output | 1 | One-cycle completion strobe |
| pc_o | output | 64 | New PC, valid with done |
| status_o | output | 32 | New status word, valid with done |
| sp_o | output | 16 | New stack pointer, valid with done |

## Verification
Two events can fall in the same cycle: the done strobe that ends one sequence and the start strobe that opens the next. A stray start can also land on the last memory access of a running sequence. The bench issues a boot fetch in the very cycle a trap reports done, and judges it by the boot fetch's own latency and access trace. It also pulses a start with changed inputs in the middle of a trap and on the final access of a return. The ignored strobe must leave the access count, the trace and all three results equal to those of an undisturbed run.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    OP_TRAP   = 2'd0,
    OP_RETURN = 2'd1,
    OP_BOOT   = 2'd2,
    OP_NONE   = 2'd3
  } trs_op_e;
endpackage

// File: rtl/trs_rst_sync.sv
module trs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_sync = ff2_q;
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int PC_BYTES = 8,
  parameter int STEP_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  trs_op_e           op_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output trs_op_e           op_o,
  output logic              done_o
);
  localparam int TRAP_LEN = 2 * PC_BYTES + 1;
  localparam int RET_LEN  = PC_BYTES + 1;
  localparam int BOOT_LEN = PC_BYTES;

  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d;
  trs_op_e           op_q, op_d;
  logic              done_q, done_d;
  int                seq_len;
  logic              accept, last;

  always_comb begin
    case (op_q)
      OP_TRAP:   seq_len = TRAP_LEN;
      OP_RETURN: seq_len = RET_LEN;
      OP_BOOT:   seq_len = BOOT_LEN;
      default:   seq_len = 1;
    endcase
    last   = busy_q && (int'(step_q) == seq_len - 1);
    accept = start_i && !busy_q && (op_i != OP_NONE);

    busy_d = busy_q;
    step_d = step_q;
    op_d   = op_q;
    done_d = last;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
      op_d   = op_i;
    end else if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      step_d = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      op_q   <= OP_NONE;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      op_q   <= op_d;
      done_q <= done_d;
    end
  end

  assign accept_o = accept;
  assign busy_o   = busy_q;
  assign last_o   = last;
  assign step_o   = step_q;
  assign op_o     = op_q;
  assign done_o   = done_q;
endmodule

// File: rtl/trs_addr_gen.sv
module trs_addr_gen
  import trs_pkg::*;
#(
  parameter int              PC_BYTES = 8,
  parameter int              AW       = 16,
  parameter int              STEP_W   = 5,
  parameter int              IDX_W    = 3,
  parameter logic [AW-1:0]   VEC_LO   = 16'hFFE0,
  parameter logic [AW-1:0]   VEC_HI   = 16'hFFF0,
  parameter logic [AW-1:0]   BOOT_VEC = 16'hFFC0
) (
  input  logic                  busy_i,
  input  trs_op_e               op_i,
  input  logic [STEP_W-1:0]     step_i,
  input  logic [AW-1:0]         sp_i,
  input  logic [8*PC_BYTES-1:0] ret_i,
  input  logic [7:0]            stat_byte_i,
  output logic [AW-1:0]         addr_o,
  output logic                  we_o,
  output logic                  re_o,
  output logic [7:0]            wdata_o,
  output logic                  push_o,
  output logic                  pull_o,
  output logic                  stat_push_o,
  output logic                  stat_pull_o,
  output logic                  pc_rd_o,
  output logic [IDX_W-1:0]      idx_o
);
  localparam int HALF = PC_BYTES / 2;

  int                    s, k;
  logic [8*PC_BYTES-1:0] sh;

  always_comb begin
    s           = int'(step_i);
    k           = 0;
    sh          = '0;
    addr_o      = '0;
    we_o        = 1'b0;
    re_o        = 1'b0;
    wdata_o     = '0;
    push_o      = 1'b0;
    pull_o      = 1'b0;
    stat_push_o = 1'b0;
    stat_pull_o = 1'b0;
    pc_rd_o     = 1'b0;
    idx_o       = '0;
    if (busy_i) begin
      case (op_i)
        OP_TRAP: begin
          if (s <= PC_BYTES) begin
            we_o   = 1'b1;
            push_o = 1'b1;
            addr_o = sp_i;
            if (s < PC_BYTES) begin
              sh      = ret_i >> (8 * (PC_BYTES - 1 - s));
              wdata_o = sh[7:0];
            end else begin
              wdata_o     = stat_byte_i;
              stat_push_o = 1'b1;
            end
          end else begin
            k       = s - (PC_BYTES + 1);
            re_o    = 1'b1;
            pc_rd_o = 1'b1;
            idx_o   = IDX_W'(k);
            if (k < HALF) addr_o = VEC_LO + AW'(k);
            else          addr_o = VEC_HI + AW'(k - HALF);
          end
        end
        OP_RETURN: begin
          re_o   = 1'b1;
          pull_o = 1'b1;
          addr_o = sp_i + 1'b1;
          if (s == 0) begin
            stat_pull_o = 1'b1;
          end else begin
            pc_rd_o = 1'b1;
            idx_o   = IDX_W'(s - 1);
          end
        end
        OP_BOOT: begin
          re_o    = 1'b1;
          pc_rd_o = 1'b1;
          idx_o   = IDX_W'(s);
          addr_o  = BOOT_VEC + AW'(s);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/trs_regs.sv
module trs_regs
  import trs_pkg::*;
#(
  parameter int PC_BYTES = 8,
  parameter int AW       = 16,
  parameter int THREADS  = 4,
  parameter int IDX_W    = 3,
  parameter int IRQ_BIT  = 2,
  localparam int PC_W    = 8 * PC_BYTES,
  localparam int ST_W    = 8 * THREADS,
  localparam int TID_W   = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic [AW-1:0]    sp_i,
  input  logic             ret_op_i,
  input  logic             last_i,
  input  logic             push_i,
  input  logic             pull_i,
  input  logic             stat_push_i,
  input  logic             stat_pull_i,
  input  logic             pc_rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       rdata_i,
  output logic [PC_W-1:0]  ret_o,
  output logic [7:0]       stat_byte_o,
  output logic [TID_W-1:0] tid_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [ST_W-1:0]  status_o,
  output logic [AW-1:0]    sp_o
);
  logic [PC_W-1:0]  ret_q, ret_d;
  logic [PC_W-1:0]  acc_q, acc_d;
  logic [ST_W-1:0]  stat_q, stat_d;
  logic [AW-1:0]    sp_q, sp_d;
  logic [TID_W-1:0] tid_q, tid_d;

  always_comb begin
    stat_byte_o = '0;
    for (int l = 0; l < THREADS; l++) begin
      if (TID_W'(l) == tid_q) stat_byte_o = stat_q[8*l +: 8];
    end
  end

  always_comb begin
    ret_d  = ret_q;
    acc_d  = acc_q;
    stat_d = stat_q;
    sp_d   = sp_q;
    tid_d  = tid_q;
    if (accept_i) begin
      ret_d  = pc_i - 1'b1;
      acc_d  = '0;
      stat_d = status_i;
      sp_d   = sp_i;
      tid_d  = tid_i;
    end else begin
      if (push_i) sp_d = sp_q - 1'b1;
      if (pull_i) sp_d = sp_q + 1'b1;
      for (int l = 0; l < THREADS; l++) begin
        if (TID_W'(l) == tid_q) begin
          if (stat_push_i) stat_d[8*l + IRQ_BIT] = 1'b1;
          if (stat_pull_i) stat_d[8*l +: 8] = rdata_i;
        end
      end
      if (pc_rd_i) begin
        for (int b = 0; b < PC_BYTES; b++) begin
          if (IDX_W'(b) == idx_i) acc_d[8*b +: 8] = rdata_i;
        end
        if (last_i && ret_op_i) acc_d = acc_d + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ret_q  <= '0;
      acc_q  <= '0;
      stat_q <= '0;
      sp_q   <= '0;
      tid_q  <= '0;
    end else begin
      ret_q  <= ret_d;
      acc_q  <= acc_d;
      stat_q <= stat_d;
      sp_q   <= sp_d;
      tid_q  <= tid_d;
    end
  end

  assign ret_o    = ret_q;
  assign tid_o    = tid_q;
  assign pc_o     = acc_q;
  assign status_o = stat_q;
  assign sp_o     = sp_q;
endmodule

// File: rtl/trap_return_seq.sv
module trap_return_seq
  import trs_pkg::*;
#(
  parameter int            PC_BYTES = 8,
  parameter int            AW       = 16,
  parameter int            THREADS  = 4,
  parameter int            IRQ_BIT  = 2,
  parameter logic [AW-1:0] VEC_LO   = 16'hFFE0,
  parameter logic [AW-1:0] VEC_HI   = 16'hFFF0,
  parameter logic [AW-1:0] BOOT_VEC = 16'hFFC0,
  localparam int PC_W    = 8 * PC_BYTES,
  localparam int ST_W    = 8 * THREADS,
  localparam int TID_W   = $clog2(THREADS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic [AW-1:0]    sp_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic [7:0]       mem_wdata_o,
  input  logic [7:0]       mem_rdata_i,
  output logic             done_o,
  output logic [PC_W-1:0]  pc_o,
  output logic [ST_W-1:0]  status_o,
  output logic [AW-1:0]    sp_o
);
  localparam int STEP_W = $clog2(2 * PC_BYTES + 2);
  localparam int IDX_W  = $clog2(PC_BYTES);

  logic              rst_n_s;
  logic              accept, busy, last;
  logic [STEP_W-1:0] step;
  trs_op_e           op_q;
  logic [PC_W-1:0]   ret;
  logic [7:0]        stat_byte;
  logic [TID_W-1:0]  tid_q;
  logic              push, pull, stat_push, stat_pull, pc_rd;
  logic [IDX_W-1:0]  idx;

  trs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  trs_ctrl #(.PC_BYTES(PC_BYTES), .STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .start_i  (start_i),
    .op_i     (trs_op_e'(op_i)),
    .accept_o (accept),
    .busy_o   (busy),
    .last_o   (last),
    .step_o   (step),
    .op_o     (op_q),
    .done_o   (done_o)
  );

  trs_addr_gen #(
    .PC_BYTES(PC_BYTES), .AW(AW), .STEP_W(STEP_W), .IDX_W(IDX_W),
    .VEC_LO(VEC_LO), .VEC_HI(VEC_HI), .BOOT_VEC(BOOT_VEC)
  ) u_addr (
    .busy_i      (busy),
    .op_i        (op_q),
    .step_i      (step),
    .sp_i        (sp_o),
    .ret_i       (ret),
    .stat_byte_i (stat_byte),
    .addr_o      (mem_addr_o),
    .we_o        (mem_we_o),
    .re_o        (mem_re_o),
    .wdata_o     (mem_wdata_o),
    .push_o      (push),
    .pull_o      (pull),
    .stat_push_o (stat_push),
    .stat_pull_o (stat_pull),
    .pc_rd_o     (pc_rd),
    .idx_o       (idx)
  );

  trs_regs #(
    .PC_BYTES(PC_BYTES), .AW(AW), .THREADS(THREADS), .IDX_W(IDX_W), .IRQ_BIT(IRQ_BIT)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .accept_i    (accept),
    .tid_i       (tid_i),
    .pc_i        (pc_i),
    .status_i    (status_i),
    .sp_i        (sp_i),
    .ret_op_i    (op_q == OP_RETURN),
    .last_i      (last),
    .push_i      (push),
    .pull_i      (pull),
    .stat_push_i (stat_push),
    .stat_pull_i (stat_pull),
    .pc_rd_i     (pc_rd),
    .idx_i       (idx),
    .rdata_i     (mem_rdata_i),
    .ret_o       (ret),
    .stat_byte_o (stat_byte),
    .tid_o       (tid_q),
    .pc_o        (pc_o),
    .status_o    (status_o),
    .sp_o        (sp_o)
  );
endmodule

// File: rtl/trs_chk.sv
module trs_chk #(
  parameter int AW      = 16,
  parameter int THREADS = 4,
  parameter int IRQ_BIT = 2,
  localparam int ST_W   = 8 * THREADS,
  localparam int TID_W  = $clog2(THREADS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             we,
  input logic             re,
  input logic [AW-1:0]    addr,
  input logic             done,
  input logic [1:0]       op_q,
  input logic [TID_W-1:0] tid_q,
  input logic [ST_W-1:0]  status
);
  // R10: one byte access per cycle, never read and write together
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

  // R7: done lasts a single cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no memory traffic while idle
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(we || re));

  // R1: consecutive pushes walk the stack downward
  p_push_walk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (we && $past(we)) |-> (addr == $past(addr) - 1'b1));

  // R4: consecutive pulls of a return walk the stack upward
  p_pull_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (re && $past(re) && op_q == 2'd1 && $past(op_q) == 2'd1) |-> (addr == $past(addr) + 1'b1));

  // R2: a finished trap leaves the thread's interrupt-disable bit set
  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == 2'd0) |-> status[8*int'(tid_q) + IRQ_BIT]);

  // R8: a start during a running sequence does not change the operation
  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(op_q));
endmodule

bind trap_return_seq trs_chk #(.AW(AW), .THREADS(THREADS), .IRQ_BIT(IRQ_BIT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n_s),
  .start  (start_i),
  .busy   (busy),
  .we     (mem_we_o),
  .re     (mem_re_o),
  .addr   (mem_addr_o),
  .done   (done_o),
  .op_q   (op_q),
  .tid_q  (tid_q),
  .status (status_o)
);

// File: tb/trap_return_seq_tb_top.sv
`timescale 1ns/1ps
module trap_return_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  op_i;
  logic [1:0]  tid_i;
  logic [63:0] pc_i;
  logic [31:0] status_i;
  logic [15:0] sp_i;
  logic [15:0] mem_addr_o;
  logic        mem_we_o, mem_re_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;
  logic        done_o;
  logic [63:0] pc_o;
  logic [31:0] status_o;
  logic [15:0] sp_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc;

  logic [7:0]  mem [logic [15:0]];
  logic [15:0] lg_addr [0:31];
  logic        lg_we   [0:31];
  logic [7:0]  lg_dat  [0:31];
  int          lg_n;

  always #2.5 clk = ~clk;

  trap_return_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .tid_i(tid_i),
    .pc_i(pc_i), .status_i(status_i), .sp_i(sp_i),
    .mem_addr_o(mem_addr_o), .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .pc_o(pc_o), .status_o(status_o), .sp_o(sp_o)
  );

  function automatic logic [7:0] rd(input logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // memory model: combinational-in-cycle read, write at mid-cycle
  always @(negedge clk) begin
    mem_rdata_i = rd(mem_addr_o);
    if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
    if ((mem_we_o || mem_re_o) && lg_n < 32) begin
      lg_addr[lg_n] = mem_addr_o;
      lg_we[lg_n]   = mem_we_o;
      lg_dat[lg_n]  = mem_we_o ? mem_wdata_o : mem_rdata_i;
      lg_n++;
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  // called at a negedge; returns at the negedge where done is seen
  task automatic run_op(input logic [1:0] op, input logic [1:0] tid, input logic [63:0] pc,
                        input logic [31:0] st, input logic [15:0] sp, input int poke_at);
    lg_n = 0;
    start_i = 1'b1; op_i = op; tid_i = tid; pc_i = pc; status_i = st; sp_i = sp;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 100) begin
      if (cyc == poke_at) begin
        start_i = 1'b1; op_i = 2'd1; tid_i = ~tid; pc_i = ~pc; status_i = ~st; sp_i = ~sp;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start_i = 1'b0;
  endtask

  task automatic do_trap(input logic [1:0] tid, input logic [63:0] pc, input logic [31:0] st,
                         input logic [15:0] sp, input int poke_at, input bit then_idle);
    logic [63:0] ret, vec;
    logic [15:0] ea;
    logic [7:0]  ed;
    bit          ok_w, ok_r;
    ret = pc - 64'd1;
    vec = '0;
    run_op(2'd0, tid, pc, st, sp, poke_at);
    chk(cyc == 18, "R7 trap latency", 64'(cyc), 64'd18);
    chk(lg_n == 17, "R10 trap access count", 64'(lg_n), 64'd17);
    ok_w = 1'b1;
    for (int k = 0; k < 9; k++) begin
      ea = sp - 16'(k);
      ed = (k < 8) ? 8'(ret >> (8 * (7 - k))) : 8'(st >> (8 * tid));
      if (!(lg_we[k] && lg_addr[k] == ea && lg_dat[k] == ed)) begin
        if (ok_w) chk(1'b0, "R1 push trace", {40'd0, lg_addr[k], lg_dat[k]}, {40'd0, ea, ed});
        ok_w = 1'b0;
      end
    end
    if (ok_w) chk(1'b1, "R1 push trace", 64'd0, 64'd0);
    ok_r = 1'b1;
    for (int k = 0; k < 8; k++) begin
      ea = (k < 4) ? 16'hFFE0 + 16'(k) : 16'hFFF0 + 16'(k - 4);
      vec[8*k +: 8] = rd(ea);
      if (!(!lg_we[9+k] && lg_addr[9+k] == ea)) begin
        if (ok_r) chk(1'b0, "R3 vector read order", 64'(lg_addr[9+k]), 64'(ea));
        ok_r = 1'b0;
      end
    end
    if (ok_r) chk(1'b1, "R3 vector read order", 64'd0, 64'd0);
    chk(pc_o == vec, "R3 trap new pc", pc_o, vec);
    chk(status_o == (st | (32'd1 << (8 * tid + 2))), "R2 irq flag set", 64'(status_o),
        64'(st | (32'd1 << (8 * tid + 2))));
    chk(sp_o == sp - 16'd9, "R6 trap sp", 64'(sp_o), 64'(sp - 16'd9));
    if (then_idle) begin
      @(negedge clk);
      chk(!done_o, "R7 done single cycle", 64'(done_o), 64'd0);
    end
  endtask

  task automatic do_return(input logic [1:0] tid, input logic [63:0] exp_pc, input logic [31:0] st,
                           input logic [15:0] sp, input logic [7:0] exp_byte, input int poke_at);
    logic [31:0] exp_st;
    bit          ok;
    exp_st = st;
    exp_st[8*tid +: 8] = exp_byte;
    run_op(2'd1, tid, 64'h0123_4567_89AB_CDEF, st, sp, poke_at);
    chk(cyc == 10, "R7 return latency", 64'(cyc), 64'd10);
    ok = (lg_n == 9);
    for (int k = 0; k < 9; k++) begin
      if (lg_we[k] || lg_addr[k] != sp + 16'(k + 1)) ok = 1'b0;
    end
    chk(ok, "R4 pull trace", 64'(lg_addr[0]), 64'(sp + 16'd1));
    chk(pc_o == exp_pc, "R4 return pc", pc_o, exp_pc);
    chk(status_o == exp_st, "R4 status lane restored", 64'(status_o), 64'(exp_st));
    chk(sp_o == sp + 16'd9, "R6 return sp", 64'(sp_o), 64'(sp + 16'd9));
    @(negedge clk);
  endtask

  task automatic do_boot(input logic [31:0] st, input logic [15:0] sp);
    logic [63:0] vec;
    bit          ok;
    ok = 1'b1;
    for (int k = 0; k < 8; k++) begin
      vec[8*k +: 8] = rd(16'hFFC0 + 16'(k));
      if (lg_addr[k] != 16'hFFC0 + 16'(k) || lg_we[k]) ok = 1'b0;
    end
    chk(cyc == 9, "R7 boot latency", 64'(cyc), 64'd9);
    chk(ok && lg_n == 8, "R5 boot trace", 64'(lg_n), 64'd8);
    chk(pc_o == vec, "R5 boot pc", pc_o, vec);
    chk(status_o == st && sp_o == sp, "R5 boot keeps status and sp", {status_o, 16'd0, sp_o},
        {st, 16'd0, sp});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    logic [63:0] pcs [0:4];
    logic [15:0] sps [0:1];
    logic [31:0] st;
    bit          quiet;
    pcs[0] = 64'd0;
    pcs[1] = 64'd1;
    pcs[2] = 64'h8000_0000_0000_801A;
    pcs[3] = 64'hFFFF_FFFF_FFFF_FFFF;
    pcs[4] = 64'h3C5A_0F96_E1D2_7B48;
    sps[0] = 16'h01FF;
    sps[1] = 16'h0003;
    rst_n = 1'b0; start_i = 1'b0; op_i = 2'd3; tid_i = '0; pc_i = '0; status_i = '0; sp_i = '0;
    mem_rdata_i = '0; lg_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(!done_o && !mem_we_o && !mem_re_o, "R9 reset quiet", {61'd0, done_o, mem_we_o, mem_re_o}, 64'd0);

    // sweep: trap then return round trip over threads, pcs, stack pointers
    for (int t = 0; t < 4; t++) begin
      for (int p = 0; p < 5; p++) begin
        for (int s = 0; s < 2; s++) begin
          st = 32'h5B18_F3A0 ^ {4{8'(p * 37 + t)}};
          st = st & ~(32'd1 << (8 * t + 2));
          do_trap(2'(t), pcs[p], st, sps[s], 0, 1'b1);
          do_return(2'(t), pcs[p], status_o, sp_o, 8'(st >> (8 * t)), 0);
        end
      end
    end

    // R5 boot fetch
    run_op(2'd2, 2'd1, 64'hDEAD, 32'h1234_5678, 16'h4444, 0);
    do_boot(32'h1234_5678, 16'h4444);
    @(negedge clk);

    // R8 op code 3 starts nothing
    lg_n = 0;
    start_i = 1'b1; op_i = 2'd3;
    @(negedge clk);
    start_i = 1'b0;
    quiet = 1'b1;
    for (int i = 0; i < 20; i++) begin
      if (done_o) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet && lg_n == 0, "R8 op 3 ignored", 64'(lg_n), 64'd0);

    // R8 start mid trap ignored; results equal an undisturbed trap
    do_trap(2'd2, 64'h0000_1111_2222_3333, 32'h0F0F_0F0F, 16'h0200, 5, 1'b1);
    // R8 start on the final access of a return ignored
    do_return(2'd2, 64'h0000_1111_2222_3333, status_o, sp_o, 8'h0F, 9);

    // R8 start in the done cycle is accepted (back to back)
    do_trap(2'd3, 64'h0000_0000_0000_8019, 32'h0000_0000, 16'h0100, 0, 1'b0);
    run_op(2'd2, 2'd0, 64'd0, 32'hA5A5_A5A5, 16'h0777, 0);
    do_boot(32'hA5A5_A5A5, 16'h0777);
    @(negedge clk);
    chk(!done_o && !mem_we_o && !mem_re_o, "R9 idle after sequences",
        {61'd0, done_o, mem_we_o, mem_re_o}, 64'd0);

    finish_run();
  end
endmodule